// File: doc/BRIEF.md
# Sleep-Mode Lock Arbiter

This block decides how deeply a system may sleep when several independent requesters share it. Each requester can take a lock on a sleep mode and later release it. Every mode has its own reference counter. A lock adds one to that counter and a release subtracts one. A mode therefore stays blocked until every requester holding it has let go.

When the main control loop asks to sleep, the block scans the counters from the shallowest mode to the deepest. It picks the first mode whose counter is not zero. If no counter is non-zero, it picks the deepest mode. The chosen mode is registered and issued together with a one-cycle go strobe. A pending interrupt cancels the request, so no strobe is issued. Lock and release traffic that arrives in the same cycle as a scan is deferred by one cycle, so the scan always reads a stable set of counts. An init input clears all counters.

Top module: `sleep_lock_arbiter`

## Requirements
- R1: A lock on mode m raises counter m by one and a release lowers it by one. A mode that was locked twice and released once remains blocked.
- R2: Mode indices run from shallow to deep: 0 idle, 1 extended standby, 2 power-save, 3 standby, 4 power-down. A scan selects the lowest index whose counter is non-zero.
- R3: If every counter is zero when a scan takes place, the selected mode is 4.
- R4: A lock or release presented in the same cycle as a sleep request is not seen by that request's scan. It is seen by any later scan.
- R5: While init is high, all counters and the error flag are cleared and any pending deferred update is discarded. A sleep request in that cycle produces no strobe.
- R6: If interrupt-pending is high in the cycle a sleep request is sampled, no go strobe follows and the mode output keeps its previous value.
- R7: A sleep request sampled at one clock edge makes the go output high for exactly the cycle after that edge. The selected mode appears on the mode output in the same cycle. The mode output changes only together with a go strobe.
- R8: Counters are 8 bits wide. A lock on a counter at 255, or a release on a counter at 0, leaves the counter unchanged and sets the error flag. The flag stays set until init.
- R9: A lock and a release of the same mode in the same cycle leave that counter unchanged and raise no error.
- R10: A lock or release that names an index of 5 or more is ignored and raises no error.
- R11: After reset, the mode output is 4, go is low and the error flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Clears counters, deferred updates and the error flag |
| lock_valid_i | input | 1 | Lock request valid |
| lock_mode_i | input | 3 | Mode index to lock |
| unlock_valid_i | input | 1 | Release request valid |
| unlock_mode_i | input | 3 | Mode index to release |
| sleep_req_i | input | 1 | Request to scan and enter sleep |
| irq_pending_i | input | 1 | An interrupt is pending; cancels the sleep request |
| sleep_mode_o | output | 3 | Registered selected sleep mode |
| sleep_go_o | output | 1 | One-cycle strobe to enter sleep |
| lock_err_o | output | 1 | Sticky counter saturation error |

## Verification
- A lock or release updates its counter at the clock edge where it is sampled, so the earliest scan that can observe it is a request sampled one edge later.
- The go strobe, the registered mode and the error flag all change at the edge that samples the request or update that causes them. The bench drives each stimulus for exactly one cycle and reads these outputs one time unit after that edge.
- Deferral is checked with two requests on consecutive edges. The first request must not observe the update, and the second must.
- Statements that something is ignored, such as a cancelled request or an out-of-range index, are checked through a later scan, the mode output and the error flag.

// File: rtl/slp_arb_pkg.sv
package slp_arb_pkg;
  // Shallow-to-deep ordering; the priority scan depends on it.
  typedef enum logic [2:0] {
    SLP_IDLE      = 3'd0,
    SLP_EXT_STBY  = 3'd1,
    SLP_SAVE      = 3'd2,
    SLP_STBY      = 3'd3,
    SLP_DOWN      = 3'd4
  } slp_mode_e;

  localparam int SLP_NUM_MODES = 5;
  localparam int SLP_CNT_W     = 8;
endpackage

// File: rtl/slp_idx_decode.sv
module slp_idx_decode #(
  parameter int NUM_MODES = 5,
  parameter int MODE_W    = 3
) (
  input  logic                 valid,
  input  logic [MODE_W-1:0]    idx,
  output logic [NUM_MODES-1:0] hot
);
  // Indices outside the mode list decode to nothing.
  for (genvar g = 0; g < NUM_MODES; g++) begin : g_dec
    assign hot[g] = valid && (idx == MODE_W'(g));
  end
endmodule

// File: rtl/slp_lock_counter.sv
module slp_lock_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             scan,
  input  logic             held_inc,
  input  logic             held_dec,
  input  logic             new_inc,
  input  logic             new_dec,
  output logic [CNT_W-1:0] cnt_q,
  output logic             eff_nz,
  output logic             sat_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] c1, c2, cnt_d;
  logic             e1, e2, cnt_en;

  // Stage 1: deferred update from the previous scan cycle.
  always_comb begin
    c1 = cnt_q;
    e1 = 1'b0;
    if (held_inc && !held_dec) begin
      if (cnt_q == CNT_MAX) e1 = 1'b1;
      else                  c1 = cnt_q + 1'b1;
    end else if (held_dec && !held_inc) begin
      if (cnt_q == '0) e1 = 1'b1;
      else             c1 = cnt_q - 1'b1;
    end
  end

  // Stage 2: update arriving this cycle.
  always_comb begin
    c2 = c1;
    e2 = 1'b0;
    if (new_inc && !new_dec) begin
      if (c1 == CNT_MAX) e2 = 1'b1;
      else               c2 = c1 + 1'b1;
    end else if (new_dec && !new_inc) begin
      if (c1 == '0) e2 = 1'b1;
      else          c2 = c1 - 1'b1;
    end
  end

  always_comb begin
    cnt_en = init | held_inc | held_dec | (!scan & (new_inc | new_dec));
    if (init)      cnt_d = '0;
    else if (scan) cnt_d = c1;
    else           cnt_d = c2;
    sat_err = !init && (e1 || (!scan && e2));
    eff_nz  = (c1 != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/slp_prio_scan.sv
module slp_prio_scan #(
  parameter int NUM_MODES = 5,
  parameter int MODE_W    = 3
) (
  input  logic [NUM_MODES-1:0] nz,
  output logic [MODE_W-1:0]    sel
);
  // Walk deep to shallow so that the shallowest non-zero entry wins.
  always_comb begin
    sel = MODE_W'(NUM_MODES - 1);
    for (int i = NUM_MODES - 1; i >= 0; i--) begin
      if (nz[i]) sel = MODE_W'(i);
    end
  end
endmodule

// File: rtl/sleep_lock_arbiter.sv
module sleep_lock_arbiter #(
  parameter int NUM_MODES = slp_arb_pkg::SLP_NUM_MODES,
  parameter int CNT_W     = slp_arb_pkg::SLP_CNT_W,
  localparam int MODE_W   = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              lock_valid_i,
  input  logic [MODE_W-1:0] lock_mode_i,
  input  logic              unlock_valid_i,
  input  logic [MODE_W-1:0] unlock_mode_i,
  input  logic              sleep_req_i,
  input  logic              irq_pending_i,
  output logic [MODE_W-1:0] sleep_mode_o,
  output logic              sleep_go_o,
  output logic              lock_err_o
);
  localparam logic [MODE_W-1:0] DEEPEST = MODE_W'(NUM_MODES - 1);

  logic [NUM_MODES-1:0] new_inc, new_dec;
  logic [NUM_MODES-1:0] held_inc_q, held_dec_q, held_inc_d, held_dec_d;
  logic [NUM_MODES-1:0] eff_nz, sat_err;
  logic [MODE_W-1:0]    sel, mode_q, mode_d;
  logic                 scan_fire, go_d, go_q, err_d, err_q, mode_en;

  slp_idx_decode #(.NUM_MODES(NUM_MODES), .MODE_W(MODE_W)) u_dec_lock (
    .valid(lock_valid_i), .idx(lock_mode_i), .hot(new_inc));
  slp_idx_decode #(.NUM_MODES(NUM_MODES), .MODE_W(MODE_W)) u_dec_unlock (
    .valid(unlock_valid_i), .idx(unlock_mode_i), .hot(new_dec));

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_unused;
    slp_lock_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .init(init_i), .scan(scan_fire),
      .held_inc(held_inc_q[g]), .held_dec(held_dec_q[g]),
      .new_inc(new_inc[g]), .new_dec(new_dec[g]),
      .cnt_q(cnt_unused), .eff_nz(eff_nz[g]), .sat_err(sat_err[g]));
  end

  slp_prio_scan #(.NUM_MODES(NUM_MODES), .MODE_W(MODE_W)) u_scan (
    .nz(eff_nz), .sel(sel));

  always_comb begin
    scan_fire = sleep_req_i && !init_i;
    go_d      = scan_fire && !irq_pending_i;
    mode_en   = go_d;
    mode_d    = sel;
    err_d     = !init_i && (err_q || (|sat_err));
    if (scan_fire) begin
      held_inc_d = new_inc;
      held_dec_d = new_dec;
    end else begin
      held_inc_d = '0;
      held_dec_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_inc_q <= '0;
      held_dec_q <= '0;
      go_q       <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      held_inc_q <= held_inc_d;
      held_dec_q <= held_dec_d;
      go_q       <= go_d;
      err_q      <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= DEEPEST;
    else if (mode_en) mode_q <= mode_d;
  end

  assign sleep_mode_o = mode_q;
  assign sleep_go_o   = go_q;
  assign lock_err_o   = err_q;
endmodule

// File: rtl/sleep_lock_arbiter_checks.sv
module sleep_lock_arbiter_checks #(
  parameter int NUM_MODES = 5,
  parameter int MODE_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_i,
  input logic              sleep_req_i,
  input logic              irq_pending_i,
  input logic [MODE_W-1:0] sleep_mode_o,
  input logic              sleep_go_o,
  input logic              lock_err_o
);
  assert_go_from_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_go_o |-> ($past(sleep_req_i) && !$past(init_i)));

  assert_irq_cancels_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending_i |=> !sleep_go_o);

  assert_init_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (!sleep_go_o && !lock_err_o));

  assert_mode_moves_with_go_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_go_o |-> $stable(sleep_mode_o));

  assert_mode_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_mode_o < MODE_W'(NUM_MODES));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lock_err_o) && !$past(init_i)) |-> lock_err_o);
endmodule

bind sleep_lock_arbiter sleep_lock_arbiter_checks #(
  .NUM_MODES(NUM_MODES), .MODE_W(MODE_W)
) u_checks (
  .clk(clk), .rst_n(rst_n), .init_i(init_i), .sleep_req_i(sleep_req_i),
  .irq_pending_i(irq_pending_i), .sleep_mode_o(sleep_mode_o),
  .sleep_go_o(sleep_go_o), .lock_err_o(lock_err_o));

// File: tb/sleep_lock_arbiter_test.sv
module sleep_lock_arbiter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_i = 1'b0, lock_valid_i = 1'b0, unlock_valid_i = 1'b0;
  logic [2:0] lock_mode_i = '0, unlock_mode_i = '0;
  logic sleep_req_i = 1'b0, irq_pending_i = 1'b0;
  logic [2:0] sleep_mode_o;
  logic sleep_go_o, lock_err_o;

  int total = 0, fails = 0;
  bit done = 0;

  // Behavioural model state, built from the requirements.
  int m_cnt[5];
  bit h_inc[5], h_dec[5];
  bit m_err;
  int exp_mode = 4;
  bit exp_go = 0;

  always #2 clk = ~clk;

  sleep_lock_arbiter uut (
    .clk(clk), .rst_n(rst_n), .init_i(init_i),
    .lock_valid_i(lock_valid_i), .lock_mode_i(lock_mode_i),
    .unlock_valid_i(unlock_valid_i), .unlock_mode_i(unlock_mode_i),
    .sleep_req_i(sleep_req_i), .irq_pending_i(irq_pending_i),
    .sleep_mode_o(sleep_mode_o), .sleep_go_o(sleep_go_o), .lock_err_o(lock_err_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step(input int m, input bit inc, input bit dec);
    if (inc && !dec) begin
      if (m_cnt[m] == 255) m_err = 1; else m_cnt[m]++;
    end else if (dec && !inc) begin
      if (m_cnt[m] == 0) m_err = 1; else m_cnt[m]--;
    end
  endtask

  task automatic cyc(input bit lv, input int lm, input bit uv, input int um,
                     input bit sr, input bit irq, input bit ini);
    lock_valid_i = lv; lock_mode_i = 3'(lm);
    unlock_valid_i = uv; unlock_mode_i = 3'(um);
    sleep_req_i = sr; irq_pending_i = irq; init_i = ini;
    exp_go = 0;
    if (ini) begin
      for (int i = 0; i < 5; i++) begin m_cnt[i] = 0; h_inc[i] = 0; h_dec[i] = 0; end
      m_err = 0;
    end else begin
      for (int i = 0; i < 5; i++) model_step(i, h_inc[i], h_dec[i]);
      if (sr) begin
        if (!irq) begin
          exp_go = 1;
          exp_mode = 4;
          for (int i = 4; i >= 0; i--) if (m_cnt[i] != 0) exp_mode = i;
        end
        for (int i = 0; i < 5; i++) begin
          h_inc[i] = lv && (lm == i);
          h_dec[i] = uv && (um == i);
        end
      end else begin
        for (int i = 0; i < 5; i++) begin
          model_step(i, lv && (lm == i), uv && (um == i));
          h_inc[i] = 0; h_dec[i] = 0;
        end
      end
    end
    @(posedge clk); #1;
    lock_valid_i = 0; unlock_valid_i = 0; sleep_req_i = 0;
    irq_pending_i = 0; init_i = 0;
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic lock(input int m); cyc(1, m, 0, 0, 0, 0, 0); endtask
  task automatic unlock(input int m); cyc(0, 0, 1, m, 0, 0, 0); endtask

  task automatic req_check(input string tag, input int want);
    cyc(0, 0, 0, 0, 1, 0, 0);
    check(sleep_go_o == 1'b1, tag, int'(sleep_go_o), 1);
    check(int'(sleep_mode_o) == want && want == exp_mode, tag, int'(sleep_mode_o), want);
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) begin m_cnt[i] = 0; h_inc[i] = 0; h_dec[i] = 0; end
    m_err = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11 reset state
    check(sleep_mode_o == 3'd4, "R11", int'(sleep_mode_o), 4);
    check(sleep_go_o == 1'b0, "R11", int'(sleep_go_o), 0);
    check(lock_err_o == 1'b0, "R11", int'(lock_err_o), 0);

    // R5 request during init gives no strobe
    cyc(0, 0, 0, 0, 1, 0, 1);
    check(sleep_go_o == 1'b0, "R5", int'(sleep_go_o), 0);

    // R2 / R3 / R7: sweep all 32 lock patterns
    for (int p = 0; p < 32; p++) begin
      int want;
      want = 4;
      for (int i = 4; i >= 0; i--) if (p[i]) want = i;
      for (int i = 0; i < 5; i++) if (p[i]) lock(i);
      req_check((p == 0) ? "R3" : "R2", want);
      idle();
      check(sleep_go_o == 1'b0, "R7", int'(sleep_go_o), 0);
      check(int'(sleep_mode_o) == want, "R7", int'(sleep_mode_o), want);
      for (int i = 0; i < 5; i++) if (p[i]) unlock(i);
      req_check("R1", 4);
    end

    // R1 reference counting
    lock(1); lock(1); unlock(1);
    req_check("R1", 1);
    unlock(1);
    req_check("R1", 4);

    // R4 deferral across a scan
    cyc(1, 1, 0, 0, 1, 0, 0);
    check(sleep_mode_o == 3'd4, "R4", int'(sleep_mode_o), 4);
    req_check("R4", 1);
    cyc(0, 0, 1, 1, 1, 0, 0);
    check(sleep_mode_o == 3'd1, "R4", int'(sleep_mode_o), 1);
    req_check("R4", 4);

    // R6 interrupt cancels
    lock(0);
    cyc(0, 0, 0, 0, 1, 1, 0);
    check(sleep_go_o == 1'b0, "R6", int'(sleep_go_o), 0);
    check(sleep_mode_o == 3'd4, "R6", int'(sleep_mode_o), 4);
    req_check("R6", 0);
    unlock(0);

    // R9 same-cycle lock and release
    cyc(1, 2, 1, 2, 0, 0, 0);
    check(lock_err_o == 1'b0, "R9", int'(lock_err_o), 0);
    req_check("R9", 4);

    // R10 out-of-range indices
    lock(6); lock(5);
    unlock(7);
    check(lock_err_o == 1'b0, "R10", int'(lock_err_o), 0);
    req_check("R10", 4);

    // R8 underflow, sticky until init (R5)
    unlock(3);
    check(lock_err_o == 1'b1, "R8", int'(lock_err_o), 1);
    idle(); idle();
    check(lock_err_o == 1'b1, "R8", int'(lock_err_o), 1);
    req_check("R8", 4);
    cyc(0, 0, 0, 0, 0, 0, 1);
    check(lock_err_o == 1'b0, "R5", int'(lock_err_o), 0);

    // R8 overflow saturation
    for (int k = 0; k < 255; k++) lock(3);
    check(lock_err_o == 1'b0, "R8", int'(lock_err_o), 0);
    lock(3);
    check(lock_err_o == 1'b1, "R8", int'(lock_err_o), 1);
    for (int k = 0; k < 254; k++) unlock(3);
    req_check("R8", 3);
    unlock(3);
    req_check("R8", 4);

    // R5 init clears counters
    lock(0); lock(2);
    cyc(0, 0, 0, 0, 0, 0, 1);
    req_check("R5", 4);
    check(lock_err_o == 1'b0, "R5", int'(lock_err_o), 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule